// File: doc/BRIEF.md
# Clocked Pulse-Logic Cell Bank

This block models a small family of single-bit cells that use pulse-coded logic, written as ordinary synchronous RTL. Every event is a strobe that is high for one cycle of a fast system clock. A cell reads a signal as 1 when at least one strobe arrived on that input during the current cell-clock period, and as 0 when none arrived. Signal strobes only change a cell's internal state. A cell emits output strobes only in response to its clock or read strobe.

The bank holds `LANES` independent lanes. Each lane contains six cells:

- a delay cell;
- an inverter;
- a two-input OR;
- a memory cell whose read does not disturb the stored bit;
- a toggle cell whose stored bit is visible as a level;
- a toggle cell that is read out in complementary form.

The delay cell, the inverter and the OR cell of a lane share one cell-clock strobe. All outputs are registered, so an output strobe appears in the cycle after the strobe that caused it.

Top module: `pulse_cell_bank`

## Requirements
- R1: Within a lane, an input counts as logic 1 for a period when one or more strobes arrived on it since the previous cell-clock strobe. The number of strobes and their order do not change the result.
- R2: Output strobes of the delay, inverter and OR cells are high for exactly one system cycle, in the cycle after a cell-clock strobe. Signal strobes alone never raise an output.
- R3: A cell-clock strobe evaluates the state collected before that cycle and then clears it. A signal strobe in the same cycle as the cell-clock strobe counts toward the next period.
- R4: The delay cell emits one strobe on `d_out` when `d_set` pulsed during the period. Otherwise it emits nothing. Extra `d_set` strobes in the same period are absorbed.
- R5: The inverter emits a strobe on `inv_out` only when `inv_in` did not pulse during the period.
- R6: The OR cell emits one strobe when `or_a`, `or_b` or both pulsed during the period. When both pulsed, it emits exactly one strobe.
- R7: In the memory cell, `nd_set` stores 1 and `nd_clr` stores 0; `nd_clr` wins when both arrive in one cycle. `nd_read` emits the stored bit on `nd_out` and leaves the bit unchanged. A read in the same cycle as a write returns the bit held before that cycle.
- R8: In the plain toggle cell, each `tg_in` strobe inverts the stored bit. The bit is shown on `tg_state` from the next cycle on.
- R9: The complementary toggle cell inverts its bit on each `tc_in` strobe. `tc_read` emits a strobe on `tc_out` only when the bit is 0, and leaves the bit at 1. A `tc_in` strobe in the same cycle as the read is applied after the read's set.
- R10: While `rst` is high, every cell state and every output is 0.
- R11: Lanes are independent: strobes on one lane never affect another lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk | input | LANES | Cell-clock strobe for the delay, inverter and OR cells of each lane |
| d_set | input | LANES | Delay cell signal strobe |
| d_out | output | LANES | Delay cell output strobe |
| inv_in | input | LANES | Inverter signal strobe |
| inv_out | output | LANES | Inverter output strobe |
| or_a | input | LANES | OR cell first signal strobe |
| or_b | input | LANES | OR cell second signal strobe |
| or_out | output | LANES | OR cell output strobe |
| nd_set | input | LANES | Memory cell write-1 strobe |
| nd_clr | input | LANES | Memory cell write-0 strobe |
| nd_read | input | LANES | Memory cell read strobe |
| nd_out | output | LANES | Memory cell read output strobe |
| tg_in | input | LANES | Plain toggle cell input strobe |
| tg_state | output | LANES | Plain toggle cell stored bit as a level |
| tc_in | input | LANES | Complementary toggle cell input strobe |
| tc_read | input | LANES | Complementary toggle cell read strobe |
| tc_out | output | LANES | Complementary toggle cell read output strobe |

## Verification
The assertions check the following on every cycle:

- any output strobe of the period cells, the memory cell or the complementary toggle cell follows a clock or read strobe one cycle earlier;
- a read without writes leaves the memory bit unchanged;
- a clear leaves the memory bit at 0;
- each toggle strobe inverts the stored bit;
- a lone complementary read leaves the bit at 1.

The bench's scenarios are needed for the behaviour that depends on the whole period. These are: several strobes collapsing to one logic value, the inverter's reversed output, the OR cell giving a single strobe when both inputs fire, a strobe that coincides with the cell clock being carried into the next period, read-during-write ordering, and lane independence.

// File: rtl/pulse_cell_pkg.sv
package pulse_cell_pkg;
  // Evaluation rule of a period cell at its clock strobe
  typedef enum logic {
    PC_PASS   = 1'b0,  // emit when any input was seen
    PC_INVERT = 1'b1   // emit when no input was seen
  } pc_kind_e;
endpackage

// File: rtl/pulse_period_cell.sv
module pulse_period_cell
  import pulse_cell_pkg::*;
#(
  parameter int       N_IN = 1,
  parameter pc_kind_e KIND = PC_PASS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] sig,
  input  logic            cclk,
  output logic            pulse_out
);
  logic [N_IN-1:0] held;
  logic            fire;

  generate
    if (KIND == PC_INVERT) begin : g_inv
      assign fire = ~|held;
    end else begin : g_pass
      assign fire = |held;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= '0;
      pulse_out <= 1'b0;
    end else begin
      pulse_out <= cclk & fire;
      if (cclk) held <= sig;          // coincident strobes open the next period
      else      held <= held | sig;
    end
  end

  // R2
  out_after_clock_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> $past(cclk));
  // R2
  out_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_out && !cclk) |=> !pulse_out);
endmodule

// File: rtl/pulse_ndro_cell.sv
module pulse_ndro_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr1,
  input  logic wr0,
  input  logic rd,
  output logic rd_out
);
  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      rd_out <= 1'b0;
    end else begin
      rd_out <= rd & bit_q;
      if (wr0)      bit_q <= 1'b0;
      else if (wr1) bit_q <= 1'b1;
    end
  end

  // R7
  read_keeps_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr1 && !wr0) |=> $stable(bit_q));
  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> !bit_q);
  // R7
  ndro_out_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_out |-> $past(rd));
endmodule

// File: rtl/pulse_toggle_cell.sv
module pulse_toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic tin,
  output logic state
);
  always_ff @(posedge clk) begin
    if (rst)      state <= 1'b0;
    else if (tin) state <= ~state;
  end

  // R8
  toggle_flips_chk: assert property (@(posedge clk) disable iff (rst)
    tin |=> (state != $past(state)));
endmodule

// File: rtl/pulse_ctoggle_cell.sv
module pulse_ctoggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic tin,
  input  logic rd,
  output logic rd_out
);
  logic bit_q;
  logic after_rd;

  assign after_rd = rd | bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      rd_out <= 1'b0;
    end else begin
      rd_out <= rd & ~bit_q;
      bit_q  <= after_rd ^ tin;
    end
  end

  // R9
  read_leaves_one_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !tin) |=> bit_q);
  // R9
  ctoggle_out_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_out |-> $past(rd));
  // R9
  ctoggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (tin && !rd) |=> (bit_q != $past(bit_q)));
endmodule

// File: rtl/pulse_cell_bank.sv
module pulse_cell_bank
  import pulse_cell_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] cclk,
  input  logic [LANES-1:0] d_set,
  output logic [LANES-1:0] d_out,
  input  logic [LANES-1:0] inv_in,
  output logic [LANES-1:0] inv_out,
  input  logic [LANES-1:0] or_a,
  input  logic [LANES-1:0] or_b,
  output logic [LANES-1:0] or_out,
  input  logic [LANES-1:0] nd_set,
  input  logic [LANES-1:0] nd_clr,
  input  logic [LANES-1:0] nd_read,
  output logic [LANES-1:0] nd_out,
  input  logic [LANES-1:0] tg_in,
  output logic [LANES-1:0] tg_state,
  input  logic [LANES-1:0] tc_in,
  input  logic [LANES-1:0] tc_read,
  output logic [LANES-1:0] tc_out
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      pulse_period_cell #(.N_IN(1), .KIND(PC_PASS)) u_delay (
        .clk(clk), .rst(rst), .sig(d_set[i]), .cclk(cclk[i]), .pulse_out(d_out[i]));

      pulse_period_cell #(.N_IN(1), .KIND(PC_INVERT)) u_inv (
        .clk(clk), .rst(rst), .sig(inv_in[i]), .cclk(cclk[i]), .pulse_out(inv_out[i]));

      pulse_period_cell #(.N_IN(2), .KIND(PC_PASS)) u_or (
        .clk(clk), .rst(rst), .sig({or_b[i], or_a[i]}), .cclk(cclk[i]),
        .pulse_out(or_out[i]));

      pulse_ndro_cell u_ndro (
        .clk(clk), .rst(rst), .wr1(nd_set[i]), .wr0(nd_clr[i]),
        .rd(nd_read[i]), .rd_out(nd_out[i]));

      pulse_toggle_cell u_tog (
        .clk(clk), .rst(rst), .tin(tg_in[i]), .state(tg_state[i]));

      pulse_ctoggle_cell u_ctog (
        .clk(clk), .rst(rst), .tin(tc_in[i]), .rd(tc_read[i]), .rd_out(tc_out[i]));
    end
  endgenerate

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (d_out == '0 && inv_out == '0 && or_out == '0 &&
             nd_out == '0 && tg_state == '0 && tc_out == '0));
endmodule

// File: tb/pulse_cell_bank_bench.sv
module pulse_cell_bank_bench;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [L-1:0] cclk = '0, d_set = '0, inv_in = '0, or_a = '0, or_b = '0;
  logic [L-1:0] nd_set = '0, nd_clr = '0, nd_read = '0, tg_in = '0;
  logic [L-1:0] tc_in = '0, tc_read = '0;
  logic [L-1:0] d_out, inv_out, or_out, nd_out, tg_state, tc_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pulse_cell_bank #(.LANES(L)) u_pulse_cell_bank (
    .clk(clk), .rst(rst), .cclk(cclk), .d_set(d_set), .d_out(d_out),
    .inv_in(inv_in), .inv_out(inv_out), .or_a(or_a), .or_b(or_b), .or_out(or_out),
    .nd_set(nd_set), .nd_clr(nd_clr), .nd_read(nd_read), .nd_out(nd_out),
    .tg_in(tg_in), .tg_state(tg_state), .tc_in(tc_in), .tc_read(tc_read),
    .tc_out(tc_out));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cell-clock strobe on the given lanes; outputs valid on return
  task automatic strobe(logic [L-1:0] lanes);
    cclk = lanes; tick(); cclk = '0;
  endtask

  task automatic flush();
    strobe('1); tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) tick();
    chk("R10", "outputs in reset",
        {2'b0, d_out, inv_out, or_out} | {2'b0, nd_out, tg_state, tc_out}, 8'h0);
    rst = 1'b0; tick();
  endtask

  task automatic t_delay();
    flush();
    d_set = 2'b01; tick(); d_set = '0; tick();
    d_set = 2'b01; tick(); d_set = '0;
    chk("R2", "no output from signal", d_out[0], 0);
    strobe(2'b01);
    chk("R1_R4", "two sets give one 1", d_out[0], 1);
    tick();
    chk("R2", "output lasts one cycle", d_out[0], 0);
    strobe(2'b01);
    chk("R4", "empty period emits nothing", d_out[0], 0);
  endtask

  task automatic t_same_cycle();
    flush();
    d_set = 2'b01; cclk = 2'b01; tick(); d_set = '0; cclk = '0;
    chk("R3", "coincident set not seen by this clock", d_out[0], 0);
    strobe(2'b01);
    chk("R3", "coincident set seen by next clock", d_out[0], 1);
  endtask

  task automatic t_inverter();
    flush();
    strobe(2'b01);
    chk("R5", "no input gives 1", inv_out[0], 1);
    inv_in = 2'b01; tick(); inv_in = '0;
    strobe(2'b01);
    chk("R5", "input gives 0", inv_out[0], 0);
  endtask

  task automatic t_or();
    flush();
    or_a = 2'b01; tick(); or_a = '0;
    strobe(2'b01);
    chk("R6", "a only", or_out[0], 1);
    or_b = 2'b01; tick(); or_b = '0;
    strobe(2'b01);
    chk("R6", "b only", or_out[0], 1);
    or_a = 2'b01; or_b = 2'b01; tick(); or_b = '0; tick(); or_a = '0;
    strobe(2'b01);
    chk("R6", "both inputs", or_out[0], 1);
    tick();
    chk("R6", "both inputs single strobe", or_out[0], 0);
    strobe(2'b01);
    chk("R6", "neither input", or_out[0], 0);
  endtask

  task automatic t_lanes();
    flush();
    d_set = 2'b10; tick(); d_set = '0;
    strobe(2'b01);
    chk("R11", "lane0 clock leaves lane1", {6'b0, d_out}, 8'h0);
    strobe(2'b10);
    chk("R11", "lane1 keeps its set", {6'b0, d_out}, 8'h2);
  endtask

  task automatic t_ndro();
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "read of 0", nd_out[0], 0);
    nd_set = 2'b01; tick(); nd_set = '0;
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "read of 1", nd_out[0], 1);
    tick();
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "second read still 1", nd_out[0], 1);
    strobe(2'b01); tick();
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "cell clock does not touch memory", nd_out[0], 1);
    nd_clr = 2'b01; tick(); nd_clr = '0;
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "read after clear", nd_out[0], 0);
    nd_set = 2'b01; nd_clr = 2'b01; tick(); nd_set = '0; nd_clr = '0;
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "clear wins over set", nd_out[0], 0);
    nd_set = 2'b01; nd_read = 2'b01; tick(); nd_set = '0; nd_read = '0;
    chk("R7", "read during set sees old bit", nd_out[0], 0);
    nd_read = 2'b01; tick(); nd_read = '0;
    chk("R7", "set then read", nd_out[0], 1);
  endtask

  task automatic t_toggle();
    tg_in = 2'b01; tick(); tg_in = '0;
    chk("R8", "first flip", tg_state[0], 1);
    tg_in = 2'b01; tick(); tg_in = '0;
    chk("R8", "second flip", tg_state[0], 0);
    tg_in = 2'b01; repeat (3) tick(); tg_in = '0;
    chk("R8", "three flips", tg_state[0], 1);
    chk("R11", "other lane toggle idle", tg_state[1], 0);
  endtask

  task automatic t_ctoggle();
    tc_read = 2'b01; tick(); tc_read = '0;
    chk("R9", "read of 0 emits", tc_out[0], 1);
    tc_read = 2'b01; tick(); tc_read = '0;
    chk("R9", "read leaves 1", tc_out[0], 0);
    tc_in = 2'b01; tick(); tc_in = '0;
    tc_read = 2'b01; tick(); tc_read = '0;
    chk("R9", "toggle back to 0 then read", tc_out[0], 1);
    tc_in = 2'b01; tc_read = 2'b01; tick(); tc_in = '0; tc_read = '0;
    chk("R9", "read with toggle sees 1", tc_out[0], 0);
    tc_read = 2'b01; tick(); tc_read = '0;
    chk("R9", "toggle applied after read set", tc_out[0], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_delay();
    t_same_cycle();
    t_inverter();
    t_or();
    t_lanes();
    t_ndro();
    t_toggle();
    t_ctoggle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule